// File: doc/BRIEF.md
# Write Cycle and Status Protection Controller

This block sits between a serial command decoder and a nonvolatile memory array. It decides when an internal write cycle begins and follows that cycle to its end. The decoder reports, while the device is selected, whether the bytes received so far make a complete write sequence and whether that sequence targets the status register. The controller commits the write when chip select is released. It then holds a busy flag for a fixed number of clocks, which stands in for the array programming time.

The controller also guards the nonvolatile status bits. A status write is refused only when the write-protect pin is low and the protection enable bit, held in the status register, is set. Either condition on its own leaves the write allowed. The protection decision is taken once, at the commit point, so later activity on the protect pin cannot affect a cycle that is already running. Chip-select activity during a cycle cannot affect it either. Any write sequence that completes while a cycle is running is discarded.

Top module: `wr_cycle_guard`

## Requirements
- R1: During and straight after reset, writeStart, busy and statusWrEn are 0 and standby is 1.
- R2: writeStart pulses for exactly one clock, in the clock after the first rising edge of clk that sees csN high following a clock that saw it low, and only if wrSeqValid is 1 at that edge. A chip-select rise with wrSeqValid at 0 starts nothing.
- R3: busy rises together with writeStart and stays high for exactly CYCLE_CLKS clocks.
- R4: Once started, a cycle runs its full length whatever csN does. standby stays 0 until busy falls, even when csN is already high.
- R5: A status write (statusWrite=1) committed while wpN=0 and protEn=1 is discarded: no writeStart and no busy.
- R6: With protEn=0, a status write starts a cycle even when wpN=0.
- R7: With wpN=1, a status write starts a cycle whatever protEn holds.
- R8: An array write (statusWrite=0) starts a cycle whatever the levels of wpN and protEn.
- R9: statusWrEn is 1 for every clock of a cycle committed as a status write and 0 for an array write. It is 0 whenever busy is 0. A change on wpN during a cycle leaves it unchanged.
- R10: A write sequence that completes while busy is 1 starts no cycle and does not change when the running cycle ends.
- R11: standby is 1 exactly when the last sampled csN was high and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select level, low selects |
| wrSeqValid | input | 1 | Decoder flag: a complete write sequence has been received |
| statusWrite | input | 1 | Decoder flag: the sequence targets the status register |
| wpN | input | 1 | Write-protect pin, low protects |
| protEn | input | 1 | Stored protection enable bit |
| writeStart | output | 1 | One-clock pulse when an internal cycle begins |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Deselected and idle |
| statusWrEn | output | 1 | The running cycle writes the status bits |

## Verification
The bench builds the block with CYCLE_CLKS set to 6. At that length a second full write sequence fits entirely inside one running cycle, so the discard rule and the cycle length are exercised in the same test. Chip-select and protect-pin toggles can also be placed inside a cycle, which shows that neither ends the cycle nor changes its target. The short cycle also lets every combination of protect pin, enable bit and write target be run back to back.

// File: rtl/wr_cycle_pkg.sv
package wr_cycle_pkg;
  typedef struct packed {
    logic load;       // commit a new internal cycle
    logic statusSel;  // committed cycle targets the status bits
  } cycle_strobe_t;
endpackage

// File: rtl/wr_cycle_ctrl.sv
module wr_cycle_ctrl
  import wr_cycle_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          wrSeqValid,
  input  logic          statusWrite,
  input  logic          wpN,
  input  logic          protEn,
  input  logic          busy,
  output logic          csHigh,
  output cycle_strobe_t strobe
);
  logic csRise;
  logic statusBlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csHigh <= 1'b1;
    else       csHigh <= csN;
  end

  assign csRise        = csN && !csHigh;
  assign statusBlocked = statusWrite && protEn && !wpN;

  always_comb begin
    strobe.load      = csRise && wrSeqValid && !busy && !statusBlocked;
    strobe.statusSel = statusWrite;
  end

  // R10
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !busy);

  // R5
  no_blocked_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.statusSel) |-> (wpN || !protEn));
endmodule

// File: rtl/wr_cycle_dp.sv
module wr_cycle_dp
  import wr_cycle_pkg::*;
#(
  parameter int CYCLE_CLKS = 40,
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  cycle_strobe_t strobe,
  output logic          writeStart,
  output logic          busy,
  output logic          statusWrEn
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      writeStart <= 1'b0;
      statusWrEn <= 1'b0;
    end else if (strobe.load) begin
      cnt        <= CNT_W'(CYCLE_CLKS);
      writeStart <= 1'b1;
      statusWrEn <= strobe.statusSel;
    end else begin
      writeStart <= 1'b0;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) statusWrEn <= 1'b0;
    end
  end

  assign busy = (cnt != '0);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> busy);

  // R3
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !writeStart) |-> $past(busy));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |=> !writeStart);

  // R9
  status_in_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWrEn |-> busy);

  // R9
  status_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !writeStart) |-> $stable(statusWrEn));
endmodule

// File: rtl/wr_cycle_guard.sv
module wr_cycle_guard
  import wr_cycle_pkg::*;
#(
  parameter int CYCLE_CLKS = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic wrSeqValid,
  input  logic statusWrite,
  input  logic wpN,
  input  logic protEn,
  output logic writeStart,
  output logic busy,
  output logic standby,
  output logic statusWrEn
);
  cycle_strobe_t strobe;
  logic          csHigh;

  wr_cycle_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .csN         (csN),
    .wrSeqValid  (wrSeqValid),
    .statusWrite (statusWrite),
    .wpN         (wpN),
    .protEn      (protEn),
    .busy        (busy),
    .csHigh      (csHigh),
    .strobe      (strobe)
  );

  wr_cycle_dp #(.CYCLE_CLKS(CYCLE_CLKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .writeStart (writeStart),
    .busy       (busy),
    .statusWrEn (statusWrEn)
  );

  assign standby = csHigh && !busy;

  // R11
  standby_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !busy);

  // R4
  standby_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && csN && $past(csN)) |-> standby);
endmodule

// File: tb/wr_cycle_guard_tb.sv
module wr_cycle_guard_tb;
  localparam int CYCLE_CLKS = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic wrSeqValid = 1'b0;
  logic statusWrite = 1'b0;
  logic wpN = 1'b1;
  logic protEn = 1'b0;
  logic writeStart, busy, standby, statusWrEn;

  int checks = 0;
  int errors = 0;
  bit expQ[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wr_cycle_guard #(.CYCLE_CLKS(CYCLE_CLKS)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrSeqValid(wrSeqValid),
    .statusWrite(statusWrite), .wpN(wpN), .protEn(protEn),
    .writeStart(writeStart), .busy(busy), .standby(standby),
    .statusWrEn(statusWrEn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: full write sequence, pushes the expected cycle when one must start
  task automatic doWrite(input bit isStatus, input bit wp, input bit en,
                         input bit valid, input bit expectStart);
    statusWrite = isStatus;
    wpN = wp;
    protEn = en;
    csN = 1'b0;
    step();
    step();
    wrSeqValid = valid;
    step();
    if (expectStart) expQ.push_back(isStatus);
    csN = 1'b1;
    step();
    wrSeqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) step();
    step();
  endtask

  // monitor: pops expected cycles and measures them
  bit active = 1'b0;
  bit expStat = 1'b0;
  int len = 0;
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      if (writeStart) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2/R5/R10: actual unexpected writeStart expected none");
        end else begin
          expStat = expQ.pop_front();
          check("R9 target at start", statusWrEn, expStat);
          check("R3 busy with start", busy, 1'b1);
        end
        active = 1'b1;
        len = 0;
      end
      if (active) begin
        if (busy) begin
          len++;
          if (statusWrEn !== expStat) begin
            checks++; errors++;
            $display("FAIL R9: actual %b expected %b", statusWrEn, expStat);
          end
        end else begin
          active = 1'b0;
          checks++;
          if (len != CYCLE_CLKS) begin
            errors++;
            $display("FAIL R3: actual %0d expected %0d", len, CYCLE_CLKS);
          end
          check("R9 cleared when idle", statusWrEn, 1'b0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step();
    // R1
    check("R1 writeStart", writeStart, 1'b0);
    check("R1 busy", busy, 1'b0);
    check("R1 statusWrEn", statusWrEn, 1'b0);
    check("R1 standby", standby, 1'b1);
    rstN = 1'b1;
    step();
    check("R1 standby after reset", standby, 1'b1);

    // R8 array write with protection active
    doWrite(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R8 busy", busy, 1'b1);
    waitIdle();

    // R2 chip-select rise without a valid sequence
    doWrite(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 no cycle", busy, 1'b0);
    check("R2 no start", writeStart, 1'b0);

    // R7 status write, pin high, enable set
    doWrite(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 busy", busy, 1'b1);
    waitIdle();

    // R6 status write, pin low, enable clear
    doWrite(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R6 busy", busy, 1'b1);
    waitIdle();

    // R5 status write blocked
    doWrite(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 no busy", busy, 1'b0);
    step();
    check("R5 still idle", busy, 1'b0);
    check("R5 standby", standby, 1'b1);

    // R4 / R9 / R11: disturb CS and WP during a status cycle
    doWrite(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R4 standby low while busy, cs high", standby, 1'b0);
    wpN = 1'b0;
    csN = 1'b0;
    step();
    check("R11 standby low while selected", standby, 1'b0);
    csN = 1'b1;
    step();
    check("R4 still busy after cs toggle", busy, 1'b1);
    check("R9 target kept after wp low", statusWrEn, 1'b1);
    waitIdle();
    check("R4 standby after cycle", standby, 1'b1);
    check("R11 idle busy", busy, 1'b0);
    wpN = 1'b1;

    // R10 second sequence during a running cycle
    doWrite(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    doWrite(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10 original cycle still running", busy, 1'b1);
    waitIdle();
    repeat (CYCLE_CLKS) step();
    check("R10 no new cycle", busy, 1'b0);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d pending starts expected 0", expQ.size());
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule